// File: doc/BRIEF.md
# Thread Block Dispatcher

This block hands the thread blocks of one kernel launch, one at a time, to a small array of streaming multiprocessors. A launch supplies the number of blocks in the grid and the cost of a single block: its thread count, its register count and its shared-memory bytes. A wide-mode bit selects the larger of two block-size ceilings. Once a launch is accepted, the dispatcher offers block IDs in ascending order on a valid/ready handshake. Each offer names a target multiprocessor.

Each multiprocessor has a ledger with five counters: resident blocks, threads, warps, registers and shared memory. A unit is eligible only when one more block keeps all five counters within their ceilings. As a result, the resource that runs out first decides how many blocks a unit holds. A completion pulse from a unit returns the cost of one block to that unit's ledger. When every block has been issued and every ledger is empty again, a level done flag rises. The flag stays high until the next launch is accepted. Every ledger counter is visible on the status outputs.

Top module: `tbd_top`

## Requirements
- R1: A multiprocessor never holds more than 8 resident blocks, whatever the block cost.
- R2: A block is charged ceil(threads/32) warps. A unit never exceeds 1024 resident threads or 32 resident warps. For example, 129-thread blocks place 6 per unit, which is 30 warps.
- R3: A unit never exceeds 32768 registers or 16384 bytes of shared memory. For example, 10000-register blocks place 3 per unit and 6000-byte blocks place 2 per unit.
- R4: A launch is rejected in any of these cases: a grid of 0 blocks; 0 threads; more threads than 512 (wide=0) or 1024 (wide=1); more registers or shared memory than one unit owns. On rejection, `launch_reject` pulses in the next cycle, nothing is dispatched, and `launch_ready` stays 1.
- R5: The target unit is the first eligible unit in circular order, starting at the unit after the last granted one. The search starts at unit 0 after each accepted launch.
- R6: Block IDs are offered in the order 0, 1, 2 and so on. An offer that is held with `disp_ready` low keeps its ID. A block counts as dispatched on the cycle where `disp_valid` and `disp_ready` are both 1.
- R7: When no unit can take the next block, `disp_valid` stays low until a completion frees room.
- R8: A completion pulse to a non-empty unit returns exactly one block's charge. If a completion and a grant hit the same unit in the same cycle, its counters do not change.
- R9: `grid_done` rises only after all blocks have been issued and all ledgers are empty. It stays high until a new launch is accepted.
- R10: `launch_ready` is 1 in every state except while a grid is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| launch_valid | input | 1 | Launch request |
| launch_ready | output | 1 | High when no grid is in progress |
| launch_wide | input | 1 | 1 selects the 1024-thread block ceiling, 0 selects the 512-thread ceiling |
| launch_grid | input | 16 | Number of blocks in the grid |
| launch_thr | input | 11 | Threads per block |
| launch_reg | input | 16 | Registers per block |
| launch_smem | input | 15 | Shared-memory bytes per block |
| launch_reject | output | 1 | One-cycle pulse after an invalid launch |
| disp_valid | output | 1 | A block is offered |
| disp_ready | input | 1 | The offered block is taken |
| disp_block | output | 16 | ID of the offered block |
| disp_sm | output | 2 | Target multiprocessor of the offered block |
| blk_done | input | 4 | One completion pulse per multiprocessor |
| grid_done | output | 1 | Whole grid issued and retired |
| occ_blk | output | 16 | Resident blocks, 4 bits per unit, unit 0 in the low bits |
| occ_thr | output | 44 | Resident threads, 11 bits per unit |
| occ_wrp | output | 24 | Resident warps, 6 bits per unit |
| occ_reg | output | 64 | Registers in use, 16 bits per unit |
| occ_smem | output | 60 | Shared memory in use, 15 bits per unit |

## Verification
A grant and a completion can fall in the same cycle on the same unit. The charge and the refund then have to cancel, with no gain or loss in any counter. The bench fills every unit to its register ceiling and retires one block on unit 1, so that unit 1 is the only eligible target. It then raises `disp_ready` in the same cycle as a second completion pulse on unit 1. The bench judges the result at the status ports. Unit 1 must still show two blocks and 20000 registers, and the next block ID must already be offered to the same unit.

// File: rtl/tbd_pkg.sv
package tbd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } tbd_state_e;

  // Rounded-up division, used for the warp charge of a block.
  function automatic int tbd_ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  // True when adding ask to used stays within cap.
  function automatic logic tbd_fits(input int used, input int ask, input int cap);
    return (used + ask) <= cap;
  endfunction

endpackage

// File: rtl/tbd_sm_ledger.sv
module tbd_sm_ledger
  import tbd_pkg::*;
#(
  parameter int MAX_BLK  = 8,
  parameter int MAX_THR  = 1024,
  parameter int MAX_WRP  = 32,
  parameter int MAX_REG  = 32768,
  parameter int MAX_SMEM = 16384,
  localparam int BLK_W  = $clog2(MAX_BLK + 1),
  localparam int THR_W  = $clog2(MAX_THR + 1),
  localparam int WRP_W  = $clog2(MAX_WRP + 1),
  localparam int REG_W  = $clog2(MAX_REG + 1),
  localparam int SMEM_W = $clog2(MAX_SMEM + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              charge,
  input  logic              retire,
  input  logic [THR_W-1:0]  ask_thr,
  input  logic [WRP_W-1:0]  ask_wrp,
  input  logic [REG_W-1:0]  ask_reg,
  input  logic [SMEM_W-1:0] ask_smem,
  output logic [BLK_W-1:0]  used_blk,
  output logic [THR_W-1:0]  used_thr,
  output logic [WRP_W-1:0]  used_wrp,
  output logic [REG_W-1:0]  used_reg,
  output logic [SMEM_W-1:0] used_smem,
  output logic              room
);

  // Named internal events, used by the assertions below.
  logic retire_ok;
  logic blk_room, thr_room, wrp_room, reg_room, smem_room;

  assign retire_ok = retire && (used_blk != '0);

  always_comb begin
    blk_room  = int'(used_blk) < MAX_BLK;
    thr_room  = tbd_fits(int'(used_thr),  int'(ask_thr),  MAX_THR);
    wrp_room  = tbd_fits(int'(used_wrp),  int'(ask_wrp),  MAX_WRP);
    reg_room  = tbd_fits(int'(used_reg),  int'(ask_reg),  MAX_REG);
    smem_room = tbd_fits(int'(used_smem), int'(ask_smem), MAX_SMEM);
    room      = blk_room && thr_room && wrp_room && reg_room && smem_room;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      used_blk  <= '0;
      used_thr  <= '0;
      used_wrp  <= '0;
      used_reg  <= '0;
      used_smem <= '0;
    end else begin
      unique case ({charge, retire_ok})
        2'b10: begin
          used_blk  <= used_blk + 1'b1;
          used_thr  <= used_thr + ask_thr;
          used_wrp  <= used_wrp + ask_wrp;
          used_reg  <= used_reg + ask_reg;
          used_smem <= used_smem + ask_smem;
        end
        2'b01: begin
          used_blk  <= used_blk - 1'b1;
          used_thr  <= used_thr - ask_thr;
          used_wrp  <= used_wrp - ask_wrp;
          used_reg  <= used_reg - ask_reg;
          used_smem <= used_smem - ask_smem;
        end
        default: ;
      endcase
    end
  end

  a_r1_blk_cap: assert property (@(posedge clk) disable iff (!rst_n)
    int'(used_blk) <= MAX_BLK);
  a_r1_charge_has_room: assert property (@(posedge clk) disable iff (!rst_n)
    charge |-> room);
  a_r2_thr_cap: assert property (@(posedge clk) disable iff (!rst_n)
    int'(used_thr) <= MAX_THR);
  a_r2_wrp_cap: assert property (@(posedge clk) disable iff (!rst_n)
    int'(used_wrp) <= MAX_WRP);
  a_r3_reg_cap: assert property (@(posedge clk) disable iff (!rst_n)
    int'(used_reg) <= MAX_REG);
  a_r3_smem_cap: assert property (@(posedge clk) disable iff (!rst_n)
    int'(used_smem) <= MAX_SMEM);
  a_r8_net_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (charge && retire_ok) |=> ($stable(used_blk) && $stable(used_reg)));
  a_r8_refund: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_ok && !charge) |=> (used_blk == $past(used_blk) - 1'b1));

endmodule

// File: rtl/tbd_rr_pick.sv
module tbd_rr_pick #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  elig,
  input  logic [IW-1:0] base,
  output logic          hit,
  output logic [IW-1:0] pick
);

  // Circular search: first eligible index at or after base.
  always_comb begin
    hit  = 1'b0;
    pick = base;
    for (int k = 0; k < N; k++) begin
      int idx;
      idx = (int'(base) + k) % N;
      if (!hit && elig[idx]) begin
        hit  = 1'b1;
        pick = IW'(idx);
      end
    end
  end

endmodule

// File: rtl/tbd_top.sv
module tbd_top
  import tbd_pkg::*;
#(
  parameter int NUM_SM      = 4,
  parameter int MAX_BLK     = 8,
  parameter int MAX_THR     = 1024,
  parameter int MAX_WRP     = 32,
  parameter int WARP_SIZE   = 32,
  parameter int MAX_REG     = 32768,
  parameter int MAX_SMEM    = 16384,
  parameter int GRID_W      = 16,
  parameter int SMALL_LIMIT = 512,
  parameter int BIG_LIMIT   = 1024,
  localparam int SM_W   = (NUM_SM > 1) ? $clog2(NUM_SM) : 1,
  localparam int BLK_W  = $clog2(MAX_BLK + 1),
  localparam int THR_W  = $clog2(MAX_THR + 1),
  localparam int WRP_W  = $clog2(MAX_WRP + 1),
  localparam int REG_W  = $clog2(MAX_REG + 1),
  localparam int SMEM_W = $clog2(MAX_SMEM + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     launch_valid,
  output logic                     launch_ready,
  input  logic                     launch_wide,
  input  logic [GRID_W-1:0]        launch_grid,
  input  logic [THR_W-1:0]         launch_thr,
  input  logic [REG_W-1:0]         launch_reg,
  input  logic [SMEM_W-1:0]        launch_smem,
  output logic                     launch_reject,
  output logic                     disp_valid,
  input  logic                     disp_ready,
  output logic [GRID_W-1:0]        disp_block,
  output logic [SM_W-1:0]          disp_sm,
  input  logic [NUM_SM-1:0]        blk_done,
  output logic                     grid_done,
  output logic [NUM_SM*BLK_W-1:0]  occ_blk,
  output logic [NUM_SM*THR_W-1:0]  occ_thr,
  output logic [NUM_SM*WRP_W-1:0]  occ_wrp,
  output logic [NUM_SM*REG_W-1:0]  occ_reg,
  output logic [NUM_SM*SMEM_W-1:0] occ_smem
);

  tbd_state_e        st;
  logic [GRID_W-1:0] grid_q;
  logic [GRID_W-1:0] next_id;
  logic [THR_W-1:0]  thr_q;
  logic [WRP_W-1:0]  wrp_q;
  logic [REG_W-1:0]  reg_q;
  logic [SMEM_W-1:0] smem_q;
  logic [SM_W-1:0]   rr_ptr;

  // Named internal events.
  logic              launch_ok, launch_take, launch_bad;
  logic              fire, issued_all, all_idle, finish, any_room;
  logic [NUM_SM-1:0] elig;
  logic [NUM_SM-1:0] charge_vec;
  logic [SM_W-1:0]   pick, nxt_ptr;
  int                thr_limit, need_wrp;

  // Launch validation.
  always_comb begin
    thr_limit = launch_wide ? BIG_LIMIT : SMALL_LIMIT;
    need_wrp  = tbd_ceil_div(int'(launch_thr), WARP_SIZE);
    launch_ok = (launch_grid != '0) && (launch_thr != '0)
             && (int'(launch_thr) <= thr_limit) && (int'(launch_thr) <= MAX_THR)
             && (need_wrp <= MAX_WRP)
             && (int'(launch_reg) <= MAX_REG) && (int'(launch_smem) <= MAX_SMEM);
  end

  assign launch_ready = (st != ST_RUN);
  assign launch_take  = launch_valid && launch_ready && launch_ok;
  assign launch_bad   = launch_valid && launch_ready && !launch_ok;

  // Target selection.
  tbd_rr_pick #(.N(NUM_SM)) u_pick (
    .elig (elig),
    .base (rr_ptr),
    .hit  (any_room),
    .pick (pick)
  );

  assign issued_all = (next_id == grid_q);
  assign disp_valid = (st == ST_RUN) && !issued_all && any_room;
  assign disp_block = next_id;
  assign disp_sm    = pick;
  assign fire       = disp_valid && disp_ready;
  assign nxt_ptr    = (pick == SM_W'(NUM_SM - 1)) ? '0 : pick + 1'b1;
  assign all_idle   = (occ_blk == '0);
  assign finish     = (st == ST_RUN) && issued_all && all_idle;
  assign grid_done  = (st == ST_DONE);

  always_comb begin
    for (int i = 0; i < NUM_SM; i++) begin
      charge_vec[i] = fire && (pick == SM_W'(i));
    end
  end

  // Per-unit ledgers.
  for (genvar g = 0; g < NUM_SM; g++) begin : g_sm
    tbd_sm_ledger #(
      .MAX_BLK (MAX_BLK),
      .MAX_THR (MAX_THR),
      .MAX_WRP (MAX_WRP),
      .MAX_REG (MAX_REG),
      .MAX_SMEM(MAX_SMEM)
    ) u_ledger (
      .clk      (clk),
      .rst_n    (rst_n),
      .charge   (charge_vec[g]),
      .retire   (blk_done[g]),
      .ask_thr  (thr_q),
      .ask_wrp  (wrp_q),
      .ask_reg  (reg_q),
      .ask_smem (smem_q),
      .used_blk (occ_blk[g*BLK_W +: BLK_W]),
      .used_thr (occ_thr[g*THR_W +: THR_W]),
      .used_wrp (occ_wrp[g*WRP_W +: WRP_W]),
      .used_reg (occ_reg[g*REG_W +: REG_W]),
      .used_smem(occ_smem[g*SMEM_W +: SMEM_W]),
      .room     (elig[g])
    );
  end

  // Grid control.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st            <= ST_IDLE;
      grid_q        <= '0;
      next_id       <= '0;
      thr_q         <= '0;
      wrp_q         <= '0;
      reg_q         <= '0;
      smem_q        <= '0;
      rr_ptr        <= '0;
      launch_reject <= 1'b0;
    end else begin
      launch_reject <= launch_bad;
      if (launch_take) begin
        st      <= ST_RUN;
        grid_q  <= launch_grid;
        thr_q   <= launch_thr;
        wrp_q   <= WRP_W'(need_wrp);
        reg_q   <= launch_reg;
        smem_q  <= launch_smem;
        next_id <= '0;
        rr_ptr  <= '0;
      end else if (st == ST_RUN) begin
        if (fire) begin
          next_id <= next_id + 1'b1;
          rr_ptr  <= nxt_ptr;
        end
        if (finish) st <= ST_DONE;
      end
    end
  end

  a_r5_target_eligible: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> elig[disp_sm]);
  a_r6_hold_id: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && !disp_ready) |=> (disp_valid && $stable(disp_block)));
  a_r6_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (disp_block == $past(disp_block) + 1'b1));
  a_r4_reject_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    launch_reject |-> (!disp_valid && launch_ready));
  a_r9_done_empty: assert property (@(posedge clk) disable iff (!rst_n)
    grid_done |-> (occ_blk == '0));
  a_r10_ready_state: assert property (@(posedge clk) disable iff (!rst_n)
    launch_take |=> !launch_ready);

endmodule

// File: tb/tb_tbd_top.sv
module tb_tbd_top;
  localparam int NS = 4;
  localparam int BW = 4;
  localparam int TW = 11;
  localparam int WW = 6;
  localparam int RW = 16;
  localparam int SW = 15;
  localparam int GW = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic launch_valid, launch_ready, launch_wide, launch_reject;
  logic [GW-1:0] launch_grid;
  logic [TW-1:0] launch_thr;
  logic [RW-1:0] launch_reg;
  logic [SW-1:0] launch_smem;
  logic disp_valid, disp_ready, grid_done;
  logic [GW-1:0] disp_block;
  logic [1:0] disp_sm;
  logic [NS-1:0] blk_done;
  logic [NS*BW-1:0] occ_blk;
  logic [NS*TW-1:0] occ_thr;
  logic [NS*WW-1:0] occ_wrp;
  logic [NS*RW-1:0] occ_reg;
  logic [NS*SW-1:0] occ_smem;

  int tests = 0, fails = 0;
  int fired, id_bad;
  logic last_valid;
  int sm_log [0:63];

  always #4 clk = ~clk;

  tbd_top dut (
    .clk(clk), .rst_n(rst_n), .launch_valid(launch_valid), .launch_ready(launch_ready),
    .launch_wide(launch_wide), .launch_grid(launch_grid), .launch_thr(launch_thr),
    .launch_reg(launch_reg), .launch_smem(launch_smem), .launch_reject(launch_reject),
    .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_block(disp_block),
    .disp_sm(disp_sm), .blk_done(blk_done), .grid_done(grid_done), .occ_blk(occ_blk),
    .occ_thr(occ_thr), .occ_wrp(occ_wrp), .occ_reg(occ_reg), .occ_smem(occ_smem)
  );

  function automatic int ob(int i); return int'(occ_blk[i*BW +: BW]); endfunction
  function automatic int ot(int i); return int'(occ_thr[i*TW +: TW]); endfunction
  function automatic int ow(int i); return int'(occ_wrp[i*WW +: WW]); endfunction
  function automatic int orr(int i); return int'(occ_reg[i*RW +: RW]); endfunction
  function automatic int osm(int i); return int'(occ_smem[i*SW +: SW]); endfunction

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One cycle: apply completions and ready at the falling edge, log any handshake.
  task automatic tick(input logic [NS-1:0] dm, input logic rdy);
    @(negedge clk);
    blk_done   = dm;
    disp_ready = rdy;
    last_valid = disp_valid;
    if (disp_valid && rdy) begin
      if (int'(disp_block) != fired) id_bad++;
      if (fired < 64) sm_log[fired] = int'(disp_sm);
      fired++;
    end
  endtask

  task automatic launch(input logic wide, input int grid, input int thr, input int regs, input int smem);
    @(negedge clk);
    launch_wide  = wide;
    launch_grid  = GW'(grid);
    launch_thr   = TW'(thr);
    launch_reg   = RW'(regs);
    launch_smem  = SW'(smem);
    launch_valid = 1'b1;
    disp_ready   = 1'b0;
    blk_done     = '0;
    @(negedge clk);
    launch_valid = 1'b0;
    fired  = 0;
    id_bad = 0;
  endtask

  task automatic run_to_stall();
    for (int n = 0; n < 300; n++) begin
      tick('0, 1'b1);
      if (!last_valid) break;
    end
    tick('0, 1'b0);
  endtask

  task automatic drain(input int grid);
    logic [NS-1:0] m;
    for (int n = 0; n < 600; n++) begin
      for (int i = 0; i < NS; i++) m[i] = (ob(i) != 0);
      if (grid_done) break;
      tick(m, 1'b1);
    end
    tick('0, 1'b0);
    chk("R9 done after drain", int'(grid_done), 1);
    chk("R6 all blocks issued", fired, grid);
    chk("R6 ascending ids", id_bad, 0);
    tick('0, 1'b0);
    chk("R9 done held", int'(grid_done), 1);
    chk("R10 ready after grid", int'(launch_ready), 1);
  endtask

  task automatic t_reset();
    chk("R10 reset ready", int'(launch_ready), 1);
    chk("R7 reset no offer", int'(disp_valid), 0);
    chk("R9 reset not done", int'(grid_done), 0);
    chk("R1 reset empty", int'(occ_blk != '0), 0);
  endtask

  task automatic reject_case(input string tag, input logic wide, input int grid, input int thr, input int regs, input int smem);
    launch(wide, grid, thr, regs, smem);
    chk(tag, int'(launch_reject), 1);
    chk("R4 ready kept", int'(launch_ready), 1);
    chk("R4 no offer", int'(disp_valid), 0);
    tick('0, 1'b0);
    chk("R4 reject is a pulse", int'(launch_reject), 0);
  endtask

  task automatic t_reject();
    reject_case("R4 600 threads narrow", 1'b0, 4, 600, 0, 0);
    reject_case("R4 zero threads", 1'b0, 4, 0, 0, 0);
    reject_case("R4 zero grid", 1'b0, 0, 32, 0, 0);
    reject_case("R4 regs over unit", 1'b0, 4, 32, 40000, 0);
    reject_case("R4 smem over unit", 1'b1, 4, 32, 0, 20000);
    reject_case("R4 1100 threads wide", 1'b1, 4, 1100, 0, 0);
    launch(1'b1, 4, 600, 0, 0);
    chk("R4 600 wide accepted", int'(launch_reject), 0);
    chk("R10 busy", int'(launch_ready), 0);
    run_to_stall();
    chk("R2 one 600-thread block per unit", fired, 4);
    chk("R2 600 threads = 19 warps", ow(0), 19);
    chk("R5 fourth block to unit 3", sm_log[3], 3);
    drain(4);
  endtask

  task automatic t_blocks();
    launch(1'b0, 40, 32, 0, 0);
    run_to_stall();
    chk("R1 32 resident", fired, 32);
    for (int i = 0; i < 8; i++) chk("R5 rotation", sm_log[i], i % NS);
    for (int i = 0; i < NS; i++) begin
      chk("R1 eight blocks", ob(i), 8);
      chk("R2 threads", ot(i), 256);
    end
    chk("R7 stalled", int'(disp_valid), 0);
    chk("R9 not done while resident", int'(grid_done), 0);
    drain(40);
  endtask

  task automatic t_warps();
    launch(1'b0, 30, 129, 0, 0);
    run_to_stall();
    chk("R2 warp ceiling count", fired, 24);
    chk("R2 warps 30", ow(2), 30);
    chk("R2 blocks 6", ob(2), 6);
    chk("R2 threads 774", ot(2), 774);
    drain(30);
  endtask

  task automatic t_threads();
    launch(1'b1, 20, 256, 0, 0);
    run_to_stall();
    chk("R2 thread ceiling count", fired, 16);
    chk("R2 threads 1024", ot(1), 1024);
    drain(20);
  endtask

  task automatic t_smem();
    launch(1'b0, 10, 64, 0, 6000);
    run_to_stall();
    chk("R3 smem ceiling count", fired, 8);
    chk("R3 smem 12000", osm(3), 12000);
    drain(10);
  endtask

  task automatic t_overlap();
    launch(1'b0, 14, 64, 10000, 0);
    run_to_stall();
    chk("R3 reg ceiling count", fired, 12);
    chk("R3 regs 30000", orr(0), 30000);
    tick(4'b0010, 1'b0);
    tick('0, 1'b0);
    chk("R8 refund", ob(1), 2);
    chk("R8 refund regs", orr(1), 20000);
    chk("R7 resumes", int'(disp_valid), 1);
    chk("R5 only unit 1 eligible", int'(disp_sm), 1);
    chk("R6 held id", int'(disp_block), 12);
    tick(4'b0010, 1'b1);
    tick('0, 1'b0);
    chk("R8 grant and refund cancel", ob(1), 2);
    chk("R8 regs unchanged", orr(1), 20000);
    chk("R6 next id", int'(disp_block), 13);
    tick('0, 1'b1);
    tick('0, 1'b0);
    chk("R1 unit 1 full again", ob(1), 3);
    chk("R9 not done yet", int'(grid_done), 0);
    drain(14);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    launch_valid = 1'b0;
    launch_wide = 1'b0;
    launch_grid = '0;
    launch_thr = '0;
    launch_reg = '0;
    launch_smem = '0;
    disp_ready = 1'b0;
    blk_done = '0;
    fired = 0;
    id_bad = 0;
    last_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_reject();
    t_blocks();
    t_warps();
    t_threads();
    t_smem();
    t_overlap();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule